// File: doc/BRIEF.md
# Timer Output Compare Unit

The block watches a free-running 16-bit timer count and compares it against a programmable compare value on every clock. On each timer tick it records whether the two were equal, giving a registered match pulse. One tick later, that registered match sets a sticky compare flag. When the interrupt enable is high, the flag drives an interrupt request. The flag is cleared either by the interrupt controller's acknowledge strobe or by a software write-one-to-clear strobe. A new setting event that lands in the same cycle as a clear wins.

One instance of the block can also define the period of its counter. With the period-source select high, the compare value is presented as the counter's TOP. With the select low, TOP is the full-scale value 0xFFFF. The TOP output advances only on tick cycles, so a change never takes effect in the middle of a timer step. Waveform pin generation belongs to a separate block.

Top module: `ocmp_unit`

## Requirements
- R1: After reset the compare value is 0x0000, `match_o`, `flag_o` and `irq_o` are 0, and `top_o` is 0xFFFF.
- R2: On a cycle with `tick_i` high, `match_o` takes the value (`cnt_i` == compare value) at the next clock edge. On a cycle with `tick_i` low, `match_o` holds its value.
- R3: On a cycle where `tick_i` and `match_o` are both high, `flag_o` is 1 after the clock edge. The flag is therefore set on the timer tick that follows the tick which saw equality.
- R4: Without a setting event or a clear, `flag_o` holds its value. In particular, equality seen with `tick_i` low never sets it.
- R5: `irq_o` is high exactly when `flag_o` is high and `irq_en_i` is high.
- R6: A high `irq_ack_i` clears `flag_o` at the next clock edge, whether or not `tick_i` is high.
- R7: A high `flag_w1c_i` clears `flag_o` at the next clock edge, whether or not `tick_i` is high.
- R8: When a setting event (R3) and a clear (R6 or R7) fall in the same cycle, `flag_o` is 1 afterwards.
- R9: On a tick cycle, `top_o` loads the compare value when `top_sel_i` is 1, and loads 0xFFFF when `top_sel_i` is 0. On a cycle without a tick, `top_o` holds.
- R10: A write (`cmp_we_i` high) loads `cmp_wdata_i` into the compare value at the next clock edge, whether or not `tick_i` is high. The comparison and the TOP selection use the new value from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer tick enable |
| cnt_i | input | 16 | Current counter value |
| cmp_we_i | input | 1 | Compare value write strobe |
| cmp_wdata_i | input | 16 | Compare value write data |
| irq_en_i | input | 1 | Interrupt enable |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears flag |
| flag_w1c_i | input | 1 | Write-one-to-clear strobe for the flag |
| top_sel_i | input | 1 | 1: compare value is counter TOP; 0: TOP is 0xFFFF |
| match_o | output | 1 | Registered match pulse |
| flag_o | output | 1 | Sticky compare flag |
| irq_o | output | 1 | Interrupt request |
| top_o | output | 16 | TOP value for the counter |

## Verification
The hardest case to reach from the ports is a setting event that coincides with a clear. This needs a registered match still pending, a tick, and an acknowledge or write-one-to-clear, all in the same cycle. The sweeps hit this case incidentally, because they run the counter through each compare value while irregular tick and clear patterns are applied. A directed sequence then forces it with both clear sources: it parks the counter on the compare value, ticks once to load the match, and ticks again with the strobe raised. The sweeps also cover compare values at 0x0000 and 0xFFFF, where the counter wraps around the compare value.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  typedef enum logic {
    TOP_FULL = 1'b0,
    TOP_CMP  = 1'b1
  } top_src_e;
endpackage

// File: rtl/ocmp_cmp_reg.sv
module ocmp_cmp_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cmp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cmp_o <= '0;
    else if (we_i) cmp_o <= wdata_i;
  end
endmodule

// File: rtl/ocmp_match.sv
module ocmp_match #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  output logic         match_o
);
  logic eq;
  assign eq = (cnt_i == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     match_o <= 1'b0;
    else if (tick_i) match_o <= eq;
  end
endmodule

// File: rtl/ocmp_flag.sv
module ocmp_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic match_i,
  input  logic ack_i,
  input  logic w1c_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  logic set_evt, clr_evt;
  assign set_evt = tick_i & match_i;
  assign clr_evt = ack_i | w1c_i;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_o <= 1'b0;
    else if (set_evt) flag_o <= 1'b1;
    else if (clr_evt) flag_o <= 1'b0;
  end

  assign irq_o = flag_o & irq_en_i;
endmodule

// File: rtl/ocmp_top_src.sv
module ocmp_top_src
  import ocmp_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  top_src_e     src_i,
  input  logic [W-1:0] cmp_i,
  output logic [W-1:0] top_o
);
  localparam logic [W-1:0] FULL = {W{1'b1}};
  logic [W-1:0] top_d;

  always_comb begin
    unique case (src_i)
      TOP_CMP:  top_d = cmp_i;
      default:  top_d = FULL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     top_o <= FULL;
    else if (tick_i) top_o <= top_d;
  end
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
  import ocmp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic             irq_en_i,
  input  logic             irq_ack_i,
  input  logic             flag_w1c_i,
  input  logic             top_sel_i,
  output logic             match_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] top_o
);
  logic [CNT_W-1:0] cmp_q;
  top_src_e         src;

  assign src = top_sel_i ? TOP_CMP : TOP_FULL;

  ocmp_cmp_reg #(.W(CNT_W)) i_cmp_reg (
    .clk_i, .rst_ni, .we_i(cmp_we_i), .wdata_i(cmp_wdata_i), .cmp_o(cmp_q)
  );

  ocmp_match #(.W(CNT_W)) i_match (
    .clk_i, .rst_ni, .tick_i, .cnt_i, .cmp_i(cmp_q), .match_o
  );

  ocmp_flag i_flag (
    .clk_i, .rst_ni, .tick_i, .match_i(match_o), .ack_i(irq_ack_i),
    .w1c_i(flag_w1c_i), .irq_en_i, .flag_o, .irq_o
  );

  ocmp_top_src #(.W(CNT_W)) i_top_src (
    .clk_i, .rst_ni, .tick_i, .src_i(src), .cmp_i(cmp_q), .top_o
  );
endmodule

// File: rtl/ocmp_unit_chk.sv
module ocmp_unit_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] cmp_q,
  input logic             irq_en_i,
  input logic             irq_ack_i,
  input logic             flag_w1c_i,
  input logic             match_o,
  input logic             flag_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] top_o
);
  // R2
  match_eq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> match_o == $past(cnt_i == cmp_q));
  // R2
  match_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(match_o));
  // R3
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && match_o |=> flag_o);
  // R4
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !irq_ack_i && !flag_w1c_i |=> $stable(flag_o));
  // R6
  ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_i && !(tick_i && match_o) |=> !flag_o);
  // R7
  w1c_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_w1c_i && !(tick_i && match_o) |=> !flag_o);
  // R5
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o && irq_en_i);
  // R9
  top_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(top_o));
endmodule

bind ocmp_unit ocmp_unit_chk #(.CNT_W(CNT_W)) i_ocmp_unit_chk (
  .clk_i, .rst_ni, .tick_i, .cnt_i, .cmp_q, .irq_en_i, .irq_ack_i,
  .flag_w1c_i, .match_o, .flag_o, .irq_o, .top_o
);

// File: tb/test_ocmp_unit.sv
module test_ocmp_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, we = 0, irq_en = 0, ack = 0, w1c = 0, sel = 0;
  logic [W-1:0] cnt = '0, wdata = '0;
  logic match, flag, irq;
  logic [W-1:0] top;

  int n_run = 0, n_fail = 0;

  // bench model state
  logic [W-1:0] m_cmp, m_top;
  logic m_match, m_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  ocmp_unit #(.CNT_W(W)) i_ocmp_unit (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cnt_i(cnt),
    .cmp_we_i(we), .cmp_wdata_i(wdata), .irq_en_i(irq_en),
    .irq_ack_i(ack), .flag_w1c_i(w1c), .top_sel_i(sel),
    .match_o(match), .flag_o(flag), .irq_o(irq), .top_o(top)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // inputs are set before the call; applies one edge and compares at negedge
  task automatic step();
    logic [W-1:0] n_cmp, n_top;
    logic n_match, n_flag;
    n_match = tick ? (cnt == m_cmp) : m_match;
    if (tick && m_match)  n_flag = 1'b1;
    else if (ack || w1c)  n_flag = 1'b0;
    else                  n_flag = m_flag;
    n_top = tick ? (sel ? m_cmp : {W{1'b1}}) : m_top;
    n_cmp = we ? wdata : m_cmp;
    @(posedge clk);
    @(negedge clk);
    m_cmp = n_cmp; m_top = n_top; m_match = n_match; m_flag = n_flag;
    chk("R2 match_o", {15'b0, match}, {15'b0, m_match});
    chk("R3/R4/R6/R7/R8 flag_o", {15'b0, flag}, {15'b0, m_flag});
    chk("R5 irq_o", {15'b0, irq}, {15'b0, m_flag & irq_en});
    chk("R9 top_o", top, m_top);
  endtask

  task automatic idle();
    tick = 0; we = 0; ack = 0; w1c = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [W-1:0] vals [5];
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF;
    vals[3] = 16'hFFFF; vals[4] = 16'h1234;
    m_cmp = '0; m_top = '1; m_match = 0; m_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 match_o", {15'b0, match}, 16'h0);
    chk("R1 flag_o", {15'b0, flag}, 16'h0);
    chk("R1 irq_o", {15'b0, irq}, 16'h0);
    chk("R1 top_o", top, 16'hFFFF);
    // R1 compare value is zero: cnt=0 with tick gives a match
    cnt = 0; sel = 1; tick = 1; step();
    chk("R1 match at cmp 0", {15'b0, match}, 16'h1);
    chk("R1 top is cmp 0", top, 16'h0000);
    idle();

    for (int b = 0; b < 10; b++) begin
      logic [W-1:0] cv;
      cv = vals[b % 5];
      sel = b[0]; irq_en = b[1];
      // R10 write without tick
      idle(); we = 1; wdata = cv; cnt = cv; step();
      we = 0; tick = 1; step();
      chk("R10 new cmp matches", {15'b0, match}, 16'h1);
      cnt = cv - 16'd6;
      for (int i = 0; i < 40; i++) begin
        tick = ((i + b) % 4) != 3;
        ack  = ((i + b) % 7) == 5;
        w1c  = ((i * 3 + b) % 11) == 6;
        step();
        if (tick) cnt = cnt + 16'd1;
      end
      // R4: equality without tick must not set
      idle(); ack = 1; step(); ack = 0;
      cnt = cv; step(); step();
      chk("R4 no set without tick", {15'b0, flag}, 16'h0);
    end

    // R8 directed: set coinciding with each clear source
    idle(); we = 1; wdata = 16'd5; cnt = 16'd5; irq_en = 1; step();
    we = 0; w1c = 1; step(); w1c = 0;
    tick = 1; step();                 // match_o loads 1
    tick = 1; ack = 1; step();        // set and ack together
    chk("R8 set beats ack", {15'b0, flag}, 16'h1);
    chk("R5 irq with flag", {15'b0, irq}, 16'h1);
    ack = 0; tick = 1; w1c = 1; step();
    chk("R8 set beats w1c", {15'b0, flag}, 16'h1);
    // R6 clear with tick high but no match
    cnt = 16'd9; tick = 1; w1c = 0; step();  // match_o -> 0
    tick = 1; ack = 1; step();
    chk("R6 ack clears during tick", {15'b0, flag}, 16'h0);
    idle();
    // R9 top holds without tick after compare change
    sel = 1; we = 1; wdata = 16'hABCD; step(); we = 0; step();
    chk("R9 top holds", top, 16'h0005);
    tick = 1; step();
    chk("R9 top loads", top, 16'hABCD);
    sel = 0; step();
    chk("R9 top full", top, 16'hFFFF);
    idle();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule